// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block drives and samples a set of general-purpose pins arranged in banks of 32 (four banks, 128 pins by default). Pin n belongs to bank n/32 and occupies bit n%32 of that bank's registers. Software reaches the block through a plain word port of valid, write, address and data signals. Read data comes back one clock after the request, on a registered return path with its own valid pulse.

Output levels are changed through half-bank registers, each covering 16 pins. The upper half of the written word is an active-low write mask, so a single store can change any subset of output bits without a read-modify-write. Each bank also has a direction register and a drive-enable register. A pad is driven only when both of its bits are set. Pin levels pass through a two-flop synchroniser and can be read back per bank.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, every output latch, direction bit and drive-enable bit is 0. `pin_out` and `pin_oe` are all zero, and the masked, direction and drive-enable registers read 0.
- R2: A write to offset 4*k (k = 0..7) updates output bits 32*(k/2) + 16*(k%2) + i, for i = 0..15. Bit i takes `wdata[i]` when mask bit `wdata[16+i]` is 0 and keeps its old value when the mask bit is 1.
- R3: A read of a masked register at offset 4*k returns its 16 current latch bits in [15:0] and zeros in [31:16].
- R4: A read of offset 0x060 + 4*b returns the synchronised levels of bank b's pins, with pin n at bit n%32.
- R5: A change on `pin_in` is seen by a read whose data is captured on the third rising edge after the change, and not by reads captured on the first or second edge.
- R6: The direction register of bank b sits at 0x204 + 0x40*b. It holds all 32 written bits and reads them back.
- R7: The drive-enable register of bank b sits at 0x208 + 0x40*b. It holds all 32 written bits and reads them back.
- R8: `pin_oe` of a pin is 1 exactly when both its direction bit and its drive-enable bit are 1. `pin_out` always follows the output latch, whatever the direction.
- R9: Reads of unmapped or non-word-aligned offsets return 0. Writes to such offsets, and to the input registers, change no state.
- R10: `rd_valid` is high for exactly the cycle after a read request and carries `rd_data`. Write requests never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| pin_in | input | 128 | Pad input levels |
| pin_out | output | 128 | Pad output values |
| pin_oe | output | 128 | Pad drive enables |

## Verification
The masked write is tried with an all-zero mask, which shows that every bit is loaded. A mask that keeps one byte and loads the other shows that the mask is honoured bit by bit. A mask that opens only the topmost bit of the last bank exposes any error in the bank and half indexing. Reading a neighbouring half register after a write tells a correct half select apart from one that writes both halves. Direction and drive-enable patterns that overlap only partly separate the AND that gates the drivers from an OR, or from either register alone. Three back-to-back input reads around a pin change pin the synchroniser latency down to one edge.

// File: rtl/gpio_bank_pkg.sv
// Shared register map constants and decode types for the banked GPIO block.
// Assumes byte addressing with 32-bit word registers.
package gpio_bank_pkg;

    localparam int MASK_BASE   = 'h000;
    localparam int IN_BASE     = 'h060;
    localparam int DIR_BASE    = 'h204;
    localparam int OE_BASE     = 'h208;
    localparam int BANK_STRIDE = 'h040;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_MASKED,
        REG_INPUT,
        REG_DIR,
        REG_DRIVE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] bank;
        logic       upper;
    } reg_sel_t;

endpackage

// File: rtl/gpio_addr_decode.sv
// Maps a byte offset onto a register kind, bank index and half select.
// Assumes NUM_BANKS <= 256. Offsets that are misaligned or unmapped give REG_NONE.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int MASK_END = MASK_BASE + 8 * NUM_BANKS;
    localparam int IN_END   = IN_BASE + 4 * NUM_BANKS;

    // Purpose: classify the offset; the first matching region wins.
    always_comb begin
        int a;
        a   = int'(addr);
        sel = '{kind: REG_NONE, bank: 8'd0, upper: 1'b0};
        if (addr[1:0] == 2'b00) begin
            if (a >= MASK_BASE && a < MASK_END) begin
                sel.kind  = REG_MASKED;
                sel.bank  = 8'((a - MASK_BASE) >> 3);
                sel.upper = addr[2];
            end else if (a >= IN_BASE && a < IN_END) begin
                sel.kind = REG_INPUT;
                sel.bank = 8'((a - IN_BASE) >> 2);
            end else begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (a == DIR_BASE + BANK_STRIDE * b) begin
                        sel.kind = REG_DIR;
                        sel.bank = 8'(b);
                    end
                    if (a == OE_BASE + BANK_STRIDE * b) begin
                        sel.kind = REG_DRIVE;
                        sel.bank = 8'(b);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpio_sync2.sv
// Two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent: there is no bus coherency across bits.
module gpio_sync2 #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    // Purpose: move pad levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// One bank of pins: the output latch with masked half-bank update, the
// direction and drive-enable registers, and the driver gating.
// Assumes BANK_W is even. The write word is BANK_W bits wide: the upper half
// is the mask, the lower half the values.
module gpio_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              upper_sel,
    input  logic              dir_we,
    input  logic              drv_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] out_q,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] drv_q,
    output logic [BANK_W-1:0] drive_en
);

    localparam int HALF = BANK_W / 2;

    logic [HALF-1:0] keep_mask;
    logic [HALF-1:0] new_val;
    logic [HALF-1:0] old_half;
    logic [HALF-1:0] merged;

    // Purpose: merge new values into the selected half under the active-low mask.
    always_comb begin
        keep_mask = wdata[BANK_W-1:HALF];
        new_val   = wdata[HALF-1:0];
        old_half  = upper_sel ? out_q[BANK_W-1:HALF] : out_q[HALF-1:0];
        merged    = (old_half & keep_mask) | (new_val & ~keep_mask);
    end

    // Purpose: hold the output latch and the two control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            drv_q <= '0;
        end else begin
            if (mask_we) begin
                if (upper_sel) out_q[BANK_W-1:HALF] <= merged;
                else           out_q[HALF-1:0]      <= merged;
            end
            if (dir_we) dir_q <= wdata;
            if (drv_we) drv_q <= wdata;
        end
    end

    // Purpose: enable a driver only when the pin is an output and its drive is enabled.
    assign drive_en = dir_q & drv_q;

endmodule

// File: rtl/gpio_banked_ctrl.sv
// Top of the banked GPIO controller. It decodes word accesses, fans write
// strobes out to the banks, synchronises the pad inputs and returns read
// data one cycle after a read request.
// Assumes BANK_W equals the 32-bit data path and accesses are word aligned.
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [BANK_W-1:0]             req_wdata,
    output logic                          rd_valid,
    output logic [BANK_W-1:0]             rd_data,
    input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
    output logic [NUM_BANKS*BANK_W-1:0]   pin_out,
    output logic [NUM_BANKS*BANK_W-1:0]   pin_oe
);

    localparam int PIN_W  = NUM_BANKS * BANK_W;
    localparam int HALF   = BANK_W / 2;
    localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    reg_sel_t          sel;
    logic              wr_req;
    logic [PIN_W-1:0]  pin_sync;
    logic [BANK_W-1:0] out_a [NUM_BANKS];
    logic [BANK_W-1:0] dir_a [NUM_BANKS];
    logic [BANK_W-1:0] drv_a [NUM_BANKS];
    logic [BANK_W-1:0] in_a  [NUM_BANKS];
    logic [BANK_W-1:0] rd_mux;
    logic [BIDX_W-1:0] bidx;

    gpio_addr_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) dec_i (
        .addr (req_addr),
        .sel  (sel)
    );

    gpio_sync2 #(.W(PIN_W)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    assign wr_req = req_valid && req_write;
    assign bidx   = sel.bank[BIDX_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_req && (sel.bank == 8'(b));

        gpio_bank #(.BANK_W(BANK_W)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .mask_we   (hit && sel.kind == REG_MASKED),
            .upper_sel (sel.upper),
            .dir_we    (hit && sel.kind == REG_DIR),
            .drv_we    (hit && sel.kind == REG_DRIVE),
            .wdata     (req_wdata),
            .out_q     (out_a[b]),
            .dir_q     (dir_a[b]),
            .drv_q     (drv_a[b]),
            .drive_en  (pin_oe[b*BANK_W +: BANK_W])
        );

        assign pin_out[b*BANK_W +: BANK_W] = out_a[b];
        assign in_a[b]                     = pin_sync[b*BANK_W +: BANK_W];
    end

    // Purpose: select the word a read returns; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        case (sel.kind)
            REG_MASKED: rd_mux = {{HALF{1'b0}},
                                  sel.upper ? out_a[bidx][BANK_W-1:HALF]
                                            : out_a[bidx][HALF-1:0]};
            REG_INPUT:  rd_mux = in_a[bidx];
            REG_DIR:    rd_mux = dir_a[bidx];
            REG_DRIVE:  rd_mux = drv_a[bidx];
            default:    rd_mux = '0;
        endcase
    end

    // Purpose: register the read return and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
// Port-level properties of the banked GPIO controller, bound to the top module.
module gpio_banked_ctrl_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [BANK_W-1:0]           req_wdata,
    input logic                        rd_valid,
    input logic [BANK_W-1:0]           rd_data,
    input logic [NUM_BANKS*BANK_W-1:0] pin_out,
    input logic [NUM_BANKS*BANK_W-1:0] pin_oe
);

    localparam int HALF = BANK_W / 2;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0));

    p_mask_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == '0) |=>
        (((pin_out[HALF-1:0] ^ $past(pin_out[HALF-1:0])) & $past(req_wdata[BANK_W-1:HALF])) == '0));

    p_mask_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == '0) |=>
        ((pin_out[HALF-1:0] & ~$past(req_wdata[BANK_W-1:HALF])) ==
         ($past(req_wdata[HALF-1:0]) & ~$past(req_wdata[BANK_W-1:HALF]))));

    p_input_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'('h060)) |=>
        ($stable(pin_out) && $stable(pin_oe)));

    p_unmapped_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'('h200)) |=> (rd_data == '0));

    p_read_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    p_read_no_side_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_write) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_banked_ctrl_tb_top.sv
// Scoreboard bench: the read task queues expected words and a monitor compares
// each returned word; pin-level checks are made directly at the falling edge.
module gpio_banked_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out;
    logic [127:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    gpio_banked_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R10 no valid after write", {127'd0, rd_valid}, 128'd0);
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare every returned word with the front of the queue.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected read return", {96'd0, rd_data}, 128'd0);
                    n_fail++;
                    $display("FAIL R10: actual valid=1 expected no pending read");
                end else begin
                    string t;
                    logic [31:0] e;
                    t = tag_q.pop_front();
                    e = exp_q.pop_front();
                    check(t, {96'd0, rd_data}, {96'd0, e});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] pins;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 pin_out reset", pin_out, '0);
        check("R1 pin_oe reset", pin_oe, '0);
        bus_read(12'h204, 32'h0, "R1 dir reset");
        bus_read(12'h208, 32'h0, "R1 drive reset");
        bus_read(12'h004, 32'h0, "R1 masked reset");

        // Masked output writes.
        bus_write(12'h000, 32'h0000_A5C3);
        check("R2 all-load", {112'd0, pin_out[15:0]}, {112'd0, 16'hA5C3});
        bus_read(12'h000, 32'h0000_A5C3, "R3 readback low half");
        bus_write(12'h000, 32'hFF00_1234);
        check("R2 byte mask", {112'd0, pin_out[15:0]}, {112'd0, 16'hA534});
        bus_read(12'h000, 32'h0000_A534, "R3 readback after mask");
        bus_write(12'h00C, 32'h0000_BEEF);
        check("R2 bank1 upper", {112'd0, pin_out[63:48]}, {112'd0, 16'hBEEF});
        check("R2 bank1 lower untouched", {112'd0, pin_out[47:32]}, 128'd0);
        bus_read(12'h00C, 32'h0000_BEEF, "R3 bank1 upper");
        bus_read(12'h008, 32'h0, "R3 bank1 lower");
        bus_write(12'h01C, 32'h7FFF_FFFF);
        check("R2 only pin 127", {96'd0, pin_out[127:96]}, {96'd0, 32'h8000_0000});
        bus_read(12'h01C, 32'h0000_8000, "R3 bank3 upper");

        // Direction and drive enable.
        bus_write(12'h204, 32'hFFFF_0000);
        bus_write(12'h208, 32'h00FF_FF00);
        check("R8 bank0 gating", {96'd0, pin_oe[31:0]}, {96'd0, 32'h00FF_0000});
        check("R8 pin_out independent", {112'd0, pin_out[15:0]}, {112'd0, 16'hA534});
        bus_read(12'h204, 32'hFFFF_0000, "R6 dir bank0");
        bus_read(12'h208, 32'h00FF_FF00, "R7 drive bank0");
        bus_write(12'h284, 32'hFFFF_FFFF);
        bus_write(12'h288, 32'h1234_5678);
        bus_write(12'h2C8, 32'hFFFF_FFFF);
        check("R8 bank2 gating", {96'd0, pin_oe[95:64]}, {96'd0, 32'h1234_5678});
        check("R8 bank3 drive only", {96'd0, pin_oe[127:96]}, 128'd0);
        bus_read(12'h284, 32'hFFFF_FFFF, "R6 dir bank2");
        bus_read(12'h2C8, 32'hFFFF_FFFF, "R7 drive bank3");

        // Inputs.
        pins = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE;
        @(negedge clk);
        pin_in = pins;
        repeat (3) @(negedge clk);
        bus_read(12'h060, pins[31:0],   "R4 input bank0");
        bus_read(12'h064, pins[63:32],  "R4 input bank1");
        bus_read(12'h068, pins[95:64],  "R4 input bank2");
        bus_read(12'h06C, pins[127:96], "R4 input bank3");

        // Synchroniser latency: reads captured one, two and three edges after a change.
        @(negedge clk);
        pin_in[31:0] = 32'h5555_AAAA;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h060;
        exp_q.push_back(pins[31:0]); tag_q.push_back("R5 first edge");
        @(negedge clk);
        exp_q.push_back(pins[31:0]); tag_q.push_back("R5 second edge");
        @(negedge clk);
        exp_q.push_back(32'h5555_AAAA); tag_q.push_back("R5 third edge");
        @(negedge clk);
        req_valid = 1'b0;

        // Unmapped and read-only offsets.
        bus_read(12'h070, 32'h0, "R9 past input regs");
        bus_read(12'h200, 32'h0, "R9 unmapped 0x200");
        bus_read(12'h020, 32'h0, "R9 past masked regs");
        bus_read(12'h206, 32'h0, "R9 misaligned");
        bus_write(12'h060, 32'hFFFF_FFFF);
        bus_read(12'h060, 32'h5555_AAAA, "R9 input write ignored");
        pins = pin_out;
        bus_write(12'h300, 32'hFFFF_FFFF);
        bus_write(12'h022, 32'h0000_FFFF);
        check("R9 unmapped write pin_out", pin_out, pins);
        check("R9 unmapped write pin_oe", {96'd0, pin_oe[31:0]}, {96'd0, 32'h00FF_0000});

        repeat (4) @(negedge clk);
        check("R10 all reads returned", {96'd0, 32'(exp_q.size())}, 128'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule